// File: doc/BRIEF.md
# Pipelined Serial ADC Host Controller

This block is the host side of a link to a serial successive-approximation converter that runs from an externally supplied bit clock. It drives the select line and the serial clock. It shifts out 8-bit command words and gathers the 10-bit conversion codes. The command word for the next conversion goes out while the code of the previous one is still arriving, so a new conversion begins every 15 or 16 serial clock periods for as long as requests keep coming.

User logic sees a one-entry request port: a strobe with a 3-bit channel number and a 2-bit power-down choice, and a busy flag. Results come back as a one-cycle pulse carrying the code and the channel it belongs to. After reset the block stays busy for a settling interval before it selects the converter. When the request stream runs dry, it clocks one extra frame of zeros to drain the last code, then releases the select line. The serial clock rate is fixed by parameters. Elaboration rejects settings that fall below 100 kHz, or above the ceiling for the chosen reference compensation (2 MHz, or 400 kHz with internal compensation).

Top module: `adc_seq_host`

## Requirements
- R1: After reset release, `busy` stays high and `adc_cs_n` high for (SYS_HZ/1e6)*PWR_US system cycles (12500 at the defaults). No request is taken and the converter is not selected during that time.
- R2: A request is taken in any cycle with `req_valid` high and `busy` low, and `busy` is high in the following cycle. It stays high until the held request is launched.
- R3: Each command word goes out MSB first, starting in the first serial slot of a frame: bit 7 = 1 (start marker), bits 6:4 = channel, bits 3:2 = the CTRL_MID parameter (default 2'b11), bits 1:0 = power-down choice.
- R4: `adc_sclk` idles low and each of its phases lasts SCLK_DIV_HALF system cycles. `adc_sdi` changes only together with a falling edge of `adc_sclk` or with the fall of `adc_cs_n`. `adc_sdo` is taken on rising edges.
- R5: Within one selection, consecutive start markers are 15 serial clocks apart when `cfg_long` is 0 and 16 apart when it is 1. `cfg_long` is sampled when the select line falls.
- R6: `adc_sdi` is 0 in every slot of a frame after its command word, so no marker is seen before the next frame begins.
- R7: The code of a conversion is the `adc_sdo` values at rising edges 9 through 18 counted from its start marker (marker edge = 0), MSB first. The two bits at edges 19 and 20 are dropped.
- R8: `res_valid` is a single-cycle pulse that carries `res_data` and `res_ch` of exactly one launched conversion. Results come out in request order.
- R9: Data clocked in before the first conversion of a selection never produces `res_valid`, so the number of pulses equals the number of launched conversions.
- R10: When a frame that launched a conversion ends with no request held, one further frame of zeros is clocked. `adc_cs_n` then rises at the end of that frame, 2P-1 rising edges after the last marker edge (P = 15 or 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request strobe |
| req_ch | input | 3 | Channel for the request |
| req_pm | input | 2 | Power-down choice for the request |
| cfg_long | input | 1 | 1 selects 16 clocks per conversion, 0 selects 15 |
| busy | output | 1 | Power-up wait active or a request is held |
| res_valid | output | 1 | Result pulse |
| res_data | output | 10 | Conversion code |
| res_ch | output | 3 | Channel of the returned code |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_sdi | output | 1 | Command data to converter |
| adc_sdo | input | 1 | Result data from converter |

## Verification
The hardest case to reach is a code whose bits straddle a frame boundary while a new command word is already going out. That case has to occur in both period modes and at the end of a stream where only the drain frame remains. The bench gets there by pushing back-to-back requests that sweep every channel and power choice, in both modes, into a converter model. The model answers each command with a distinct code and nonzero trailing sub-bits. Isolated single requests then cover the case of a selection holding one conversion followed by one drain frame.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
   localparam int unsigned CTRL_BITS   = 8;
   localparam int unsigned RES_BITS    = 10;
   localparam int unsigned CH_BITS     = 3;
   localparam int unsigned PM_BITS     = 2;
   localparam int unsigned SLOT_W      = 5;
   localparam int unsigned RES_FIRST   = 9;
   localparam int unsigned RES_LAST    = RES_FIRST + RES_BITS - 1;
   localparam int unsigned SUB_LAST    = RES_LAST + 2;
   localparam int unsigned SHORT_SPAN  = 15;
   localparam int unsigned LONG_SPAN   = 16;
   localparam int unsigned MIN_SCLK_HZ = 100_000;
   localparam int unsigned EXT_MAX_HZ  = 2_000_000;
   localparam int unsigned INT_MAX_HZ  = 400_000;

   typedef enum logic [1:0] {
      ST_PWRUP = 2'd0,
      ST_IDLE  = 2'd1,
      ST_RUN   = 2'd2
   } host_st_t;
endpackage

// File: rtl/adc_host_sclk.sv
module adc_host_sclk #(
   parameter int unsigned DIV_HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap      = (cnt == CNT_W'(DIV_HALF - 1));
   assign rise_tick = run & wrap & ~sclk;
   assign fall_tick = run & wrap & sclk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else begin
         cnt <= wrap ? '0 : cnt + 1'b1;
         if (wrap) sclk <= ~sclk;
      end
   end

   p_rise_drives_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |=> sclk);
   p_fall_drives_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_tick |=> !sclk);
endmodule

// File: rtl/adc_host_frame.sv
module adc_host_frame
   import adc_host_pkg::*;
#(
   parameter int unsigned PWR_WAIT = 12500,
   parameter logic [1:0]  CTRL_MID = 2'b11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [CH_BITS-1:0]  req_ch,
   input  logic [PM_BITS-1:0]  req_pm,
   input  logic                cfg_long,
   input  logic                fall_tick,
   output logic                busy,
   output logic                run,
   output logic                cs_n,
   output logic                sdi,
   output logic [SLOT_W-1:0]   slot,
   output logic                cur_conv,
   output logic                prev_conv,
   output logic                long_q,
   output logic [CH_BITS-1:0]  prev_ch
);
   localparam int unsigned PW_W = $clog2(PWR_WAIT + 1);

   host_st_t               st;
   logic [PW_W-1:0]        pw_cnt;
   logic                   pend_full;
   logic [CH_BITS-1:0]     pend_ch;
   logic [PM_BITS-1:0]     pend_pm;
   logic [CH_BITS-1:0]     cur_ch;
   logic [CTRL_BITS-2:0]   sh;
   logic [CTRL_BITS-1:0]   nxt_byte;
   logic [SLOT_W-1:0]      last_slot;
   logic                   frame_end;
   logic                   accept;

   assign nxt_byte  = {1'b1, pend_ch, CTRL_MID, pend_pm};
   assign last_slot = long_q ? SLOT_W'(LONG_SPAN - 1) : SLOT_W'(SHORT_SPAN - 1);
   assign frame_end = fall_tick && (slot == last_slot);
   assign busy      = (st == ST_PWRUP) || pend_full;
   assign accept    = req_valid && !busy;
   assign run       = (st == ST_RUN);
   assign cs_n      = ~run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_PWRUP;
         pw_cnt    <= '0;
         pend_full <= 1'b0;
         pend_ch   <= '0;
         pend_pm   <= '0;
         cur_ch    <= '0;
         prev_ch   <= '0;
         sh        <= '0;
         sdi       <= 1'b0;
         slot      <= '0;
         cur_conv  <= 1'b0;
         prev_conv <= 1'b0;
         long_q    <= 1'b0;
      end else begin
         if (accept) begin
            pend_full <= 1'b1;
            pend_ch   <= req_ch;
            pend_pm   <= req_pm;
         end else if (pend_full && ((st == ST_IDLE) || (run && frame_end))) begin
            pend_full <= 1'b0;
         end

         case (st)
            ST_PWRUP: begin
               if (pw_cnt == PW_W'(PWR_WAIT - 1)) st <= ST_IDLE;
               else                                pw_cnt <= pw_cnt + 1'b1;
            end
            ST_IDLE: begin
               if (pend_full) begin
                  st        <= ST_RUN;
                  long_q    <= cfg_long;
                  prev_conv <= 1'b0;
                  slot      <= '0;
                  sdi       <= 1'b1;
                  sh        <= nxt_byte[CTRL_BITS-2:0];
                  cur_conv  <= 1'b1;
                  cur_ch    <= pend_ch;
               end
            end
            ST_RUN: begin
               if (frame_end) begin
                  prev_conv <= cur_conv;
                  prev_ch   <= cur_ch;
                  slot      <= '0;
                  if (pend_full) begin
                     sdi      <= 1'b1;
                     sh       <= nxt_byte[CTRL_BITS-2:0];
                     cur_conv <= 1'b1;
                     cur_ch   <= pend_ch;
                  end else begin
                     sdi      <= 1'b0;
                     cur_conv <= 1'b0;
                     if (!cur_conv) st <= ST_IDLE;
                  end
               end else if (fall_tick) begin
                  slot <= slot + 1'b1;
                  sdi  <= sh[CTRL_BITS-2];
                  sh   <= {sh[CTRL_BITS-3:0], 1'b0};
               end
            end
            default: st <= ST_PWRUP;
         endcase
      end
   end

   p_accept_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);
   p_byte_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && slot >= SLOT_W'(CTRL_BITS)) |-> !sdi);
   p_select_with_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> sdi);
   p_no_select_in_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_cnt != PW_W'(PWR_WAIT - 1)) |-> cs_n);
endmodule

// File: rtl/adc_host_rx.sv
module adc_host_rx
   import adc_host_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise_tick,
   input  logic [SLOT_W-1:0]   slot,
   input  logic                cur_conv,
   input  logic                prev_conv,
   input  logic                long_q,
   input  logic [CH_BITS-1:0]  prev_ch,
   input  logic                sdo,
   output logic                res_valid,
   output logic [RES_BITS-1:0] res_data,
   output logic [CH_BITS-1:0]  res_ch
);
   logic [SLOT_W-1:0]   span;
   logic [SLOT_W-1:0]   prev_rel;
   logic                grab;
   logic                done;
   logic [RES_BITS-1:0] sh;

   assign span     = long_q ? SLOT_W'(LONG_SPAN) : SLOT_W'(SHORT_SPAN);
   assign prev_rel = slot + span;
   assign grab     = rise_tick &&
                     ((cur_conv && slot >= SLOT_W'(RES_FIRST)) ||
                      (prev_conv && prev_rel <= SLOT_W'(RES_LAST)));
   assign done     = rise_tick && prev_conv && (prev_rel == SLOT_W'(SUB_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh        <= '0;
         res_valid <= 1'b0;
         res_data  <= '0;
         res_ch    <= '0;
      end else begin
         if (grab) sh <= {sh[RES_BITS-2:0], sdo};
         res_valid <= done;
         if (done) begin
            res_data <= sh;
            res_ch   <= prev_ch;
         end
      end
   end

   p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   p_only_after_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(prev_conv));
endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
   import adc_host_pkg::*;
#(
   parameter int unsigned SYS_HZ        = 125_000_000,
   parameter int unsigned SCLK_DIV_HALF = 32,
   parameter int unsigned PWR_US        = 100,
   parameter bit          INT_COMP      = 1'b0,
   parameter logic [1:0]  CTRL_MID      = 2'b11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_ch,
   input  logic [1:0]    req_pm,
   input  logic          cfg_long,
   output logic          busy,
   output logic          res_valid,
   output logic [9:0]    res_data,
   output logic [2:0]    res_ch,
   output logic          adc_cs_n,
   output logic          adc_sclk,
   output logic          adc_sdi,
   input  logic          adc_sdo
);
   localparam int unsigned SCLK_HZ  = SYS_HZ / (2 * SCLK_DIV_HALF);
   localparam int unsigned PWR_WAIT = (SYS_HZ / 1_000_000) * PWR_US;

   if (INT_COMP) begin : g_int_comp
      if (SCLK_HZ > INT_MAX_HZ) begin : g_too_fast
         $error("serial clock above internal-compensation ceiling");
      end
   end else begin : g_ext_comp
      if (SCLK_HZ > EXT_MAX_HZ) begin : g_too_fast
         $error("serial clock above external-compensation ceiling");
      end
   end
   if (SCLK_HZ < MIN_SCLK_HZ) begin : g_too_slow
      $error("serial clock below hold-droop floor");
   end
   if (PWR_WAIT < 1) begin : g_no_wait
      $error("power-up wait must be at least one cycle");
   end

   logic                run;
   logic                rise_tick;
   logic                fall_tick;
   logic [SLOT_W-1:0]   slot;
   logic                cur_conv;
   logic                prev_conv;
   logic                long_q;
   logic [CH_BITS-1:0]  prev_ch;

   adc_host_sclk #(.DIV_HALF(SCLK_DIV_HALF)) clk_gen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .sclk      (adc_sclk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   adc_host_frame #(.PWR_WAIT(PWR_WAIT), .CTRL_MID(CTRL_MID)) frame_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ch    (req_ch),
      .req_pm    (req_pm),
      .cfg_long  (cfg_long),
      .fall_tick (fall_tick),
      .busy      (busy),
      .run       (run),
      .cs_n      (adc_cs_n),
      .sdi       (adc_sdi),
      .slot      (slot),
      .cur_conv  (cur_conv),
      .prev_conv (prev_conv),
      .long_q    (long_q),
      .prev_ch   (prev_ch)
   );

   adc_host_rx rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_tick (rise_tick),
      .slot      (slot),
      .cur_conv  (cur_conv),
      .prev_conv (prev_conv),
      .long_q    (long_q),
      .prev_ch   (prev_ch),
      .sdo       (adc_sdo),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_ch    (res_ch)
   );

   p_idle_clock_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk);
   p_result_while_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(!adc_cs_n));
endmodule

// File: tb/adc_seq_host_tb_top.sv
module adc_seq_host_tb_top;
   localparam int unsigned HALF     = 32;
   localparam int unsigned PWR_WAIT = 12500;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_ch = '0;
   logic [1:0] req_pm = '0;
   logic       cfg_long = 1'b0;
   logic       busy, res_valid, adc_cs_n, adc_sclk, adc_sdi;
   logic [9:0] res_data;
   logic [2:0] res_ch;
   logic       adc_sdo = 1'b0;

   always #4 clk = ~clk;

   adc_seq_host dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
      .req_pm(req_pm), .cfg_long(cfg_long), .busy(busy), .res_valid(res_valid),
      .res_data(res_data), .res_ch(res_ch), .adc_cs_n(adc_cs_n),
      .adc_sclk(adc_sclk), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo)
   );

   int tests = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // request log and converter model state
   int req_log_ch [256];
   int req_log_pm [256];
   int exp_word   [256];
   int exp_ch     [256];
   int n_req = 0;
   int n_conv = 0;
   int n_res = 0;
   int m_cur_r = -1;
   int m_prev_r = -1;
   int m_cur_word = 0;
   int m_prev_word = 0;
   logic [7:0] m_ctrl = '0;
   int rise_cnt = 0;
   int last_start = 0;
   bit armed = 1'b0;
   int sdi_viol = 0;
   int hi_checks = 0;
   time t_rise = 0;

   function automatic int span();
      return cfg_long ? 16 : 15;
   endfunction

   function automatic logic bit_of(input int word, input int idx);
      if (idx >= 9 && idx <= 18) return word[18 - idx];
      if (idx == 19 || idx == 20) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge adc_sclk) begin
      t_rise = $time;
      if (!adc_cs_n) begin
         rise_cnt++;
         if (m_prev_r >= 0) m_prev_r++;
         if (m_prev_r > 20) m_prev_r = -1;
         if (m_cur_r >= 0) m_cur_r++;
         if (m_cur_r >= 1 && m_cur_r <= 7) begin
            m_ctrl = {m_ctrl[6:0], adc_sdi};
            if (m_cur_r == 7) begin
               check(int'(m_ctrl[6:4]) == req_log_ch[n_conv], "R3 channel field", int'(m_ctrl[6:4]), req_log_ch[n_conv]);
               check(int'(m_ctrl[1:0]) == req_log_pm[n_conv], "R3 power field", int'(m_ctrl[1:0]), req_log_pm[n_conv]);
               check(m_ctrl[3:2] == 2'b11, "R3 fixed middle bits", int'(m_ctrl[3:2]), 3);
               m_cur_word = (int'(m_ctrl[6:4]) * 113 + int'(m_ctrl[1:0]) * 29 + n_conv * 37 + 5) % 1024;
               exp_word[n_conv] = m_cur_word;
               exp_ch[n_conv] = int'(m_ctrl[6:4]);
               n_conv++;
            end
         end else if ((m_cur_r < 0 || m_cur_r >= 8) && adc_sdi) begin
            if (m_cur_r >= 0) begin
               check(m_cur_r >= span(), "R6 no marker before frame end", m_cur_r, span());
               check(rise_cnt - last_start == span(), "R5 marker spacing", rise_cnt - last_start, span());
            end
            m_prev_r = m_cur_r;
            m_prev_word = m_cur_word;
            m_cur_r = 0;
            m_ctrl = 8'h01;
            last_start = rise_cnt;
            armed = 1'b1;
         end
      end
   end

   always @(negedge adc_sclk) begin
      if (hi_checks < 4 && !adc_cs_n) begin
         hi_checks++;
         check(($time - t_rise) == HALF * 8, "R4 sclk high phase", int'(($time - t_rise) / 8), HALF);
      end
      if (m_cur_r >= 0 && m_cur_r + 1 >= 8 && m_cur_r + 1 <= 20)
         adc_sdo = bit_of(m_cur_word, m_cur_r + 1);
      else if (m_prev_r >= 0 && m_prev_r + 1 >= 8 && m_prev_r + 1 <= 20)
         adc_sdo = bit_of(m_prev_word, m_prev_r + 1);
      else
         adc_sdo = 1'b0;
   end

   always @(posedge adc_cs_n) begin
      if (armed) begin
         check(rise_cnt - last_start == 2 * span() - 1, "R10 drain frame length", rise_cnt - last_start, 2 * span() - 1);
         check(n_res == n_conv, "R9 pulse count per selection", n_res, n_conv);
      end
      m_cur_r = -1;
      m_prev_r = -1;
      adc_sdo = 1'b0;
   end

   logic sdi_q = 1'b0;
   logic sclk_q = 1'b0;
   always @(negedge clk) begin
      if (rst_n && adc_sdi != sdi_q && sclk_q && adc_sclk) sdi_viol++;
      sdi_q = adc_sdi;
      sclk_q = adc_sclk;
      if (rst_n && res_valid) begin
         check(int'(res_data) == exp_word[n_res], "R7 result code", int'(res_data), exp_word[n_res]);
         check(int'(res_ch) == exp_ch[n_res], "R8 result channel", int'(res_ch), exp_ch[n_res]);
         n_res++;
      end
   end

   task automatic issue(input int ch, input int pm);
      while (busy) @(negedge clk);
      req_log_ch[n_req] = ch;
      req_log_pm[n_req] = pm;
      n_req++;
      req_valid = 1'b1;
      req_ch = 3'(ch);
      req_pm = 2'(pm);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
   endtask

   task automatic drain();
      while (n_res < n_req) @(negedge clk);
      while (!adc_cs_n) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(adc_cs_n == 1'b1 && adc_sclk == 1'b0 && busy == 1'b1, "R1 reset state",
            int'({adc_cs_n, adc_sclk, busy}), 5);
      rst_n = 1'b1;
      begin
         int cnt = 0;
         int sel = 0;
         req_valid = 1'b1;
         while (busy) begin
            @(negedge clk);
            cnt++;
            if (!adc_cs_n) sel++;
         end
         req_valid = 1'b0;
         check(cnt >= PWR_WAIT && cnt <= PWR_WAIT + 1, "R1 power-up wait", cnt, PWR_WAIT);
         check(sel == 0, "R1 no select during wait", sel, 0);
         check(n_conv == 0, "R1 no request taken during wait", n_conv, 0);
      end
      for (int md = 0; md < 2; md++) begin
         cfg_long = md[0];
         for (int ch = 0; ch < 8; ch++)
            for (int pm = 0; pm < 4; pm++)
               issue(ch, pm);
         drain();
      end
      for (int md = 0; md < 2; md++) begin
         cfg_long = md[0];
         issue(5, 2);
         drain();
      end
      check(n_res == n_req, "R8 all results returned", n_res, n_req);
      check(sdi_viol == 0, "R4 sdi stable while sclk high", sdi_viol, 0);
      done_flag = 1'b1;
      report();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done_flag) begin
         tests++;
         fails++;
         $display("FAIL watchdog R8 actual=%0d expected=%0d", n_res, n_req);
         report();
      end
   end
endmodule